// File: doc/BRIEF.md
# ULPI Transceiver Register Read Responder

This block is the transceiver-side logic that answers register reads issued by a ULPI link. While the link owns the data bus, the block samples every byte. When a byte carries the read opcode, the block raises NXT to take the command. For an ordinary read it then grabs the bus by raising DIR. It lets one turnaround cycle pass with the bus undriven, presents the addressed byte for exactly one cycle, and drops DIR to hand the bus back.

A command whose six-bit address field holds the escape value 6'h2F starts a two-byte read. NXT stays high for a second cycle, and the byte the link places on the bus during that cycle becomes the full eight-bit address. Only then is DIR raised. After every read the block ignores the bus for the turnaround cycle. It then waits for the link to drive the Idle byte before it will decode another command.

The storage holds a parameterised number of implemented locations, each loaded at reset with a fixed pattern. Short (six-bit) addresses and extended (eight-bit) addresses index the same storage.

Top module: `ulpi_rd_responder`

## Requirements
- R1: During and right after reset, `dir`, `nxt` and `phy_drive` are 0 and `phy_data` is 8'h00.
- R2: In the waiting state, a link byte with bits [7:6] equal to 2'b11 is taken as a read command, and `nxt` is 1 with `dir` 0 in the next cycle.
- R3: In the waiting state, a link byte whose bits [7:6] are not 2'b11 leaves `nxt` and `dir` at 0.
- R4: In the cycle after the last cycle with `nxt` high, `dir` is 1, `nxt` is 0 and `phy_drive` is 0 (turnaround).
- R5: In the cycle after the turnaround, `phy_drive` is 1 and `phy_data` carries the addressed register, for exactly one cycle.
- R6: In the cycle after the data cycle, `dir` and `phy_drive` are 0.
- R7: When the command's bits [5:0] equal 6'h2F, `nxt` stays 1 for a second cycle. The byte on the bus in that second cycle becomes the 8-bit read address, and `dir` rises only after it.
- R8: Location a holds a XOR 8'h5A for a below NUM_IMPL (default 64) and reads as 8'h00 otherwise. A short address a (a ≠ 6'h2F) reads the same location as extended address a.
- R9: After `dir` falls, a read command on the bus leaves `nxt` at 0 until the link has driven the Idle byte 8'h00 for a cycle.
- R10: Whenever `phy_drive` is 0, `phy_data` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| link_data | input | 8 | Byte driven by the link onto the shared bus |
| phy_data | output | 8 | Byte this block drives onto the shared bus |
| phy_drive | output | 1 | Output enable for `phy_data` |
| dir | output | 1 | Bus direction, 1 while the transceiver owns the bus |
| nxt | output | 1 | Command-accept handshake to the link |

## Verification
The bench checks the turnaround cycle directly. A design that drove data in the same cycle DIR rises, or held NXT high alongside DIR, is caught at the first sample after DIR rises. Extended reads are checked at escape address 2F, at a location shared with a short address, and above the implemented range. A responder that latched the command byte instead of the second byte, or that raised DIR one cycle early, returns the wrong value or fails the NXT check. A read command is placed on the bus during the return turnaround and held there with no Idle in between. A responder that re-armed immediately would raise NXT there. Bytes with other opcodes are applied and must leave the handshake quiet.

// File: rtl/ulpi_rd_pkg.sv
package ulpi_rd_pkg;

    localparam int          BYTE_W     = 8;
    localparam logic [1:0]  OP_READ    = 2'b11;
    localparam logic [5:0]  ADDR_ESC   = 6'h2F;
    localparam logic [7:0]  BUS_IDLE   = 8'h00;
    localparam logic [7:0]  SEED_MASK  = 8'h5A;

    typedef enum logic [2:0] {
        ST_LISTEN,
        ST_ACK,
        ST_EXTADDR,
        ST_TURN_IN,
        ST_DRIVE,
        ST_TURN_OUT,
        ST_WAIT_IDLE
    } rd_state_e;

    typedef struct packed {
        logic       is_read;
        logic       is_ext;
        logic [5:0] short_addr;
    } rd_cmd_t;

    function automatic logic [BYTE_W-1:0] seed_byte(input logic [BYTE_W-1:0] a);
        return a ^ SEED_MASK;
    endfunction

endpackage

// File: rtl/ulpi_rd_decode.sv
module ulpi_rd_decode
    import ulpi_rd_pkg::*;
(
    input  logic [BYTE_W-1:0] bus_byte,
    output rd_cmd_t           cmd,
    output logic              is_idle
);

    always_comb begin
        cmd.is_read    = (bus_byte[7:6] == OP_READ);
        cmd.short_addr = bus_byte[5:0];
        cmd.is_ext     = cmd.is_read && (bus_byte[5:0] == ADDR_ESC);
        is_idle        = (bus_byte == BUS_IDLE);
    end

endmodule

// File: rtl/ulpi_rd_regfile.sv
module ulpi_rd_regfile
    import ulpi_rd_pkg::*;
#(
    parameter int NUM_IMPL = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);

    localparam int IDX_W = (NUM_IMPL > 1) ? $clog2(NUM_IMPL) : 1;

    logic [BYTE_W-1:0] store [NUM_IMPL];

    for (genvar g = 0; g < NUM_IMPL; g++) begin : g_loc
        always_ff @(posedge clk) begin
            if (rst) store[g] <= seed_byte(BYTE_W'(g));
            else     store[g] <= store[g];
        end
    end

    logic in_range;
    logic [IDX_W-1:0] idx;

    always_comb begin
        in_range = (32'(raddr) < NUM_IMPL);
        idx      = IDX_W'(raddr);
        rdata    = in_range ? store[idx] : '0;
    end

    initial begin
        p_depth_fits_r8: assert (NUM_IMPL >= 1 && NUM_IMPL <= 256);
    end

endmodule

// File: rtl/ulpi_rd_fsm.sv
module ulpi_rd_fsm
    import ulpi_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] bus_byte,
    input  rd_cmd_t           cmd,
    input  logic              is_idle,
    output logic              nxt,
    output logic              dir,
    output logic              drive,
    output logic [BYTE_W-1:0] raddr
);

    rd_state_e         state_q;
    logic              ext_q;
    logic [BYTE_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LISTEN;
            ext_q   <= 1'b0;
            addr_q  <= '0;
        end else begin
            unique case (state_q)
                ST_LISTEN: if (cmd.is_read) begin
                    state_q <= ST_ACK;
                    ext_q   <= cmd.is_ext;
                    addr_q  <= {2'b00, cmd.short_addr};
                end
                ST_ACK:       state_q <= ext_q ? ST_EXTADDR : ST_TURN_IN;
                ST_EXTADDR: begin
                    addr_q  <= bus_byte;
                    state_q <= ST_TURN_IN;
                end
                ST_TURN_IN:   state_q <= ST_DRIVE;
                ST_DRIVE:     state_q <= ST_TURN_OUT;
                ST_TURN_OUT:  state_q <= ST_WAIT_IDLE;
                ST_WAIT_IDLE: if (is_idle) state_q <= ST_LISTEN;
                default:      state_q <= ST_LISTEN;
            endcase
        end
    end

    always_comb begin
        nxt   = (state_q == ST_ACK) || (state_q == ST_EXTADDR);
        dir   = (state_q == ST_TURN_IN) || (state_q == ST_DRIVE);
        drive = (state_q == ST_DRIVE);
        raddr = addr_q;
    end

    p_nxt_dir_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(nxt && dir));

    p_turn_undriven_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(dir) |-> !drive);

    p_dir_after_nxt_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(dir) |-> $past(nxt));

    p_drive_then_turn_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(drive) |-> $past(dir));

    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        drive |=> (!drive && !dir));

    p_no_rearm_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(dir) |=> !nxt);

endmodule

// File: rtl/ulpi_rd_responder.sv
module ulpi_rd_responder
    import ulpi_rd_pkg::*;
#(
    parameter int NUM_IMPL = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] link_data,
    output logic [7:0] phy_data,
    output logic       phy_drive,
    output logic       dir,
    output logic       nxt
);

    rd_cmd_t           cmd;
    logic              is_idle;
    logic [BYTE_W-1:0] raddr;
    logic [BYTE_W-1:0] rdata;

    ulpi_rd_decode u_decode (
        .bus_byte (link_data),
        .cmd      (cmd),
        .is_idle  (is_idle)
    );

    ulpi_rd_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .bus_byte (link_data),
        .cmd      (cmd),
        .is_idle  (is_idle),
        .nxt      (nxt),
        .dir      (dir),
        .drive    (phy_drive),
        .raddr    (raddr)
    );

    ulpi_rd_regfile #(.NUM_IMPL(NUM_IMPL)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign phy_data = phy_drive ? rdata : '0;

    p_quiet_bus_r10: assert property (@(posedge clk) disable iff (rst)
        !phy_drive |-> (phy_data == 8'h00));

    p_drive_owns_r5: assert property (@(posedge clk) disable iff (rst)
        phy_drive |-> dir);

endmodule

// File: tb/ulpi_rd_responder_bench.sv
module ulpi_rd_responder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int IMPL = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] link_data = 8'h00;
    logic [7:0] phy_data;
    logic       phy_drive, dir, nxt;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ulpi_rd_responder #(.NUM_IMPL(IMPL)) u_ulpi_rd_responder (
        .clk       (clk),
        .rst       (rst),
        .link_data (link_data),
        .phy_data  (phy_data),
        .phy_drive (phy_drive),
        .dir       (dir),
        .nxt       (nxt)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [7:0] a);
        return (int'(a) < IMPL) ? (a ^ 8'h5A) : 8'h00;
    endfunction

    // One full read: command, optional extended byte, turnarounds, Idle wait.
    task automatic do_read(input logic [7:0] cmd, input logic [7:0] ext,
                           input bit is_ext, input logic [7:0] exp);
        @(negedge clk) link_data = cmd;
        @(negedge clk);
        chk("R2 nxt on command", {7'd0, nxt}, 8'd1);
        chk("R2 dir low on command", {7'd0, dir}, 8'd0);
        if (is_ext) begin
            @(negedge clk);
            chk("R7 nxt second cycle", {7'd0, nxt}, 8'd1);
            chk("R7 dir still low", {7'd0, dir}, 8'd0);
            link_data = ext;
        end
        @(negedge clk);
        chk("R4 dir turnaround", {7'd0, dir}, 8'd1);
        chk("R4 nxt dropped", {7'd0, nxt}, 8'd0);
        chk("R4 bus undriven", {7'd0, phy_drive}, 8'd0);
        chk("R10 quiet in turnaround", phy_data, 8'h00);
        link_data = 8'hFF;
        @(negedge clk);
        chk("R5 driving", {7'd0, phy_drive}, 8'd1);
        chk("R8 read value", phy_data, exp);
        link_data = 8'hC1;
        @(negedge clk);
        chk("R6 dir released", {7'd0, dir}, 8'd0);
        chk("R6 drive released", {7'd0, phy_drive}, 8'd0);
        @(negedge clk);
        chk("R9 no rearm in turnaround", {7'd0, nxt}, 8'd0);
        @(negedge clk);
        chk("R9 no rearm before Idle", {7'd0, nxt}, 8'd0);
        link_data = 8'h00;
        @(negedge clk);
    endtask

    task automatic test_reset();
        chk("R1 dir", {7'd0, dir}, 8'd0);
        chk("R1 nxt", {7'd0, nxt}, 8'd0);
        chk("R1 drive", {7'd0, phy_drive}, 8'd0);
        chk("R1 data", phy_data, 8'h00);
    endtask

    task automatic test_ignored(input logic [7:0] b);
        @(negedge clk) link_data = b;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R3 nxt quiet", {7'd0, nxt}, 8'd0);
            chk("R3 dir quiet", {7'd0, dir}, 8'd0);
        end
        link_data = 8'h00;
        @(negedge clk);
    endtask

    task automatic test_short_reads();
        do_read(8'hC0, 8'h00, 1'b0, model(8'h00));
        do_read(8'hC5, 8'h00, 1'b0, model(8'h05));
        do_read(8'hEE, 8'h00, 1'b0, model(8'h2E));
        do_read(8'hFF, 8'h00, 1'b0, model(8'h3F));
    endtask

    task automatic test_ext_reads();
        do_read(8'hEF, 8'h2F, 1'b1, model(8'h2F));
        do_read(8'hEF, 8'h10, 1'b1, model(8'h10));
        do_read(8'hD0, 8'h00, 1'b0, model(8'h10));
        do_read(8'hEF, 8'hC8, 1'b1, 8'h00);
        do_read(8'hEF, 8'h40, 1'b1, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_ignored(8'h80);
        test_ignored(8'h45);
        test_ignored(8'h2F);
        test_short_reads();
        test_ext_reads();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule